// File: doc/BRIEF.md
# Pull-Model Burst DMA with Completion Reordering

This block lets an accelerator fetch its own input from a 2 MB shared host memory window and return results to it. The host never writes device registers for individual data words. It fills the lower half of the window with raw input, pulses a job start with a length counted in 64-byte bursts, and later collects the processed output from the upper half. The device issues every transfer itself.

A read engine issues one burst request per 64-byte block of the source half, tagging each with a reorder slot number. Completions come back on a 64-bit response port. Bursts may return in any order, but the beats of one burst arrive in order. An eight-slot reorder buffer puts the data back in request order and streams it to the processing core over a valid/ready handshake. Results from the core collect in a one-burst staging buffer and are written as eight-beat bursts to the destination half.

Read requests and write bursts share one outbound bus. An arbiter alternates between the two kinds when both are waiting. It never lets a destination burst go out before the matching source burst has been handed to the core.

Top module: `pull_dma`

## Requirements
- R1: After reset, busy, done, err, ob_valid and src_valid are all low.
- R2: A start pulse while idle with job_len greater than 16384 sets err, clears done and issues no outbound request. Any other start while idle clears err and done. A start while busy is ignored: the running job keeps its length.
- R3: The n-th read request of a job (n from 0) is a single beat with ob_wr=0, ob_last=1, ob_addr=n*64 and ob_tag=n mod 8. A job of L bursts issues exactly L read requests.
- R4: At most 8 read bursts are outstanding, counted from request acceptance to delivery of the burst's last beat to the core. A tag is never reissued while its slot still holds undelivered data.
- R5: Completion beats (cpl_tag selects the slot, beats of one tag in order) are delivered on src_data in request order, whatever the completion order. src_last is high on the eighth beat of each burst.
- R6: Once src_valid is high without src_ready, src_valid and src_data hold until accepted.
- R7: The m-th write burst is eight beats with ob_wr=1 and ob_addr=0x100000+m*64 on every beat. It carries the core results in order, has ob_last only on the eighth beat, and no read request is granted between its beats.
- R8: Write burst m is not granted before source burst m has been fully delivered to the core.
- R9: When a read request and a complete write burst are both pending at a grant decision, the grant goes to the kind that did not win the previous grant.
- R10: Once ob_valid is high without ob_ready, ob_valid, ob_wr, ob_addr, ob_tag and ob_data hold until accepted.
- R11: done rises and busy falls in the cycle after the last beat of write burst L-1 is accepted. A zero-length start raises done one cycle after the start without any transfer.
- R12: res_ready is low exactly while the staging buffer holds eight results that have not yet been fully written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job start pulse |
| job_len | input | 16 | Job length in 64-byte bursts |
| busy | output | 1 | Job running |
| done | output | 1 | Last job completed |
| err | output | 1 | Last start rejected for length |
| ob_valid | output | 1 | Outbound beat valid |
| ob_ready | input | 1 | Outbound beat accepted |
| ob_wr | output | 1 | 1 = write data beat, 0 = read request |
| ob_addr | output | 21 | Byte address within the window |
| ob_tag | output | 3 | Reorder slot of a read request |
| ob_data | output | 64 | Write data (zero for read requests) |
| ob_last | output | 1 | Last beat of the outbound transaction |
| cpl_valid | input | 1 | Completion beat valid |
| cpl_tag | input | 3 | Slot the completion belongs to |
| cpl_data | input | 64 | Completion data |
| src_valid | output | 1 | Source word to core valid |
| src_ready | input | 1 | Core accepts source word |
| src_data | output | 64 | Source word in request order |
| src_last | output | 1 | Last word of a burst |
| res_valid | input | 1 | Result word from core valid |
| res_ready | output | 1 | Block accepts result word |
| res_data | input | 64 | Result word |

## Verification
A wrong reorder pointer or slot count shows up on the first delivered beat of the affected burst, as a src_data word belonging to another block, or as a stall that never clears. A corrupted read or write counter shows as a wrong ob_addr or ob_tag on the very next outbound transaction. A slip in the staging fill count shows within one burst as res_ready disagreeing with the number of results held. Arbitration faults show at the next grant decision where both kinds are waiting, and a wrong job counter shows as done rising a cycle early or late.

// File: rtl/pull_dma_pkg.sv
`timescale 1ns/1ps
package pull_dma_pkg;
    // Grant held on the outbound bus while a beat is stalled
    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_RD   = 2'd1,
        LK_WR   = 2'd2
    } grant_lock_e;
endpackage

// File: rtl/pull_dma_rob.sv
`timescale 1ns/1ps
// Completion reorder buffer: one slot of BEATS words per tag, drained in tag order.
module pull_dma_rob #(
    parameter int DW    = 64,
    parameter int BEATS = 8,
    parameter int TAGS  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     cpl_valid,
    input  logic [$clog2(TAGS)-1:0]  cpl_tag,
    input  logic [DW-1:0]            cpl_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [DW-1:0]            out_data,
    output logic                     out_last,
    output logic                     freed
);
    localparam int TW = $clog2(TAGS);
    localparam int BW = $clog2(BEATS);
    localparam int CW = $clog2(BEATS + 1);

    typedef struct packed {
        logic [TAGS-1:0][CW-1:0] cnt;
        logic [TW-1:0]           head;
        logic [BW-1:0]           beat;
    } rob_st_t;

    rob_st_t s_q, s_d;
    logic [DW-1:0] mem_q [TAGS*BEATS];
    logic [TW+BW-1:0] widx, ridx;
    logic fire;

    assign widx      = {cpl_tag, s_q.cnt[cpl_tag][BW-1:0]};
    assign ridx      = {s_q.head, s_q.beat};
    assign out_valid = (s_q.cnt[s_q.head] == CW'(BEATS));
    assign out_data  = mem_q[ridx];
    assign out_last  = (s_q.beat == BW'(BEATS - 1));
    assign fire      = out_valid & out_ready;
    assign freed     = fire & out_last;

    always_comb begin
        s_d = s_q;
        if (cpl_valid) begin
            s_d.cnt[cpl_tag] = s_q.cnt[cpl_tag] + 1'b1;
        end
        if (fire) begin
            s_d.beat = s_q.beat + 1'b1;
            if (out_last) begin
                s_d.cnt[s_q.head] = '0;
                s_d.head          = s_q.head + 1'b1;
            end
        end
        if (clr) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (cpl_valid) mem_q[widx] <= cpl_data;
    end
endmodule

// File: rtl/pull_dma_wstage.sv
`timescale 1ns/1ps
// One-burst staging buffer between the core's result stream and the write engine.
module pull_dma_wstage #(
    parameter int DW    = 64,
    parameter int BEATS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          full,
    output logic [DW-1:0] tx_data,
    output logic          tx_last,
    input  logic          tx_go
);
    localparam int BW = $clog2(BEATS);
    localparam int CW = $clog2(BEATS + 1);

    typedef struct packed {
        logic [CW-1:0] fill;
        logic [BW-1:0] idx;
    } ws_st_t;

    ws_st_t s_q, s_d;
    logic [DW-1:0] buf_q [BEATS];

    assign full     = (s_q.fill == CW'(BEATS));
    assign in_ready = !full;
    assign tx_data  = buf_q[s_q.idx];
    assign tx_last  = (s_q.idx == BW'(BEATS - 1));

    always_comb begin
        s_d = s_q;
        if (in_valid && in_ready) begin
            s_d.fill = s_q.fill + 1'b1;
        end
        if (tx_go) begin
            s_d.idx = s_q.idx + 1'b1;
            if (tx_last) s_d.fill = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (in_valid && in_ready) buf_q[s_q.fill[BW-1:0]] <= in_data;
    end
endmodule

// File: rtl/pull_dma.sv
`timescale 1ns/1ps
// Job control, read/write engines and outbound arbitration.
module pull_dma #(
    parameter int DW         = 64,
    parameter int BEATS      = 8,
    parameter int TAGS       = 8,
    parameter int AW         = 21,
    parameter int LENW       = 16,
    parameter int MAX_BURSTS = 16384
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [LENW-1:0]         job_len,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    output logic                    ob_valid,
    input  logic                    ob_ready,
    output logic                    ob_wr,
    output logic [AW-1:0]           ob_addr,
    output logic [$clog2(TAGS)-1:0] ob_tag,
    output logic [DW-1:0]           ob_data,
    output logic                    ob_last,
    input  logic                    cpl_valid,
    input  logic [$clog2(TAGS)-1:0] cpl_tag,
    input  logic [DW-1:0]           cpl_data,
    output logic                    src_valid,
    input  logic                    src_ready,
    output logic [DW-1:0]           src_data,
    output logic                    src_last,
    input  logic                    res_valid,
    output logic                    res_ready,
    input  logic [DW-1:0]           res_data
);
    import pull_dma_pkg::*;

    localparam int TW   = $clog2(TAGS);
    localparam int OFS  = $clog2(BEATS * DW / 8);
    localparam int CNTW = $clog2(MAX_BURSTS + 1);
    localparam logic [AW-1:0] DST_BASE = AW'(1) << (AW - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          err;
        logic          last_wr;
        logic          wr_active;
        grant_lock_e   lock;
        logic [CNTW-1:0] len;
        logic [CNTW-1:0] rd_issued;
        logic [CNTW-1:0] rd_drained;
        logic [CNTW-1:0] wr_sent;
    } ctl_st_t;

    ctl_st_t s_q, s_d;

    logic          rob_clr, rob_freed;
    logic          ws_full, ws_last, ws_go;
    logic [DW-1:0] ws_data;
    logic [CNTW-1:0] outstanding;
    logic          rd_pend, wr_pend, g_rd, g_wr, ob_fire;

    pull_dma_rob #(.DW(DW), .BEATS(BEATS), .TAGS(TAGS)) u_rob (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rob_clr),
        .cpl_valid (cpl_valid),
        .cpl_tag   (cpl_tag),
        .cpl_data  (cpl_data),
        .out_valid (src_valid),
        .out_ready (src_ready),
        .out_data  (src_data),
        .out_last  (src_last),
        .freed     (rob_freed)
    );

    pull_dma_wstage #(.DW(DW), .BEATS(BEATS)) u_ws (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (res_valid),
        .in_ready (res_ready),
        .in_data  (res_data),
        .full     (ws_full),
        .tx_data  (ws_data),
        .tx_last  (ws_last),
        .tx_go    (ws_go)
    );

    assign outstanding = s_q.rd_issued - s_q.rd_drained;
    assign rd_pend = s_q.busy && (s_q.rd_issued < s_q.len) && (outstanding < CNTW'(TAGS));
    assign wr_pend = s_q.busy && ws_full && (s_q.wr_sent < s_q.rd_drained);

    // Grant: a started write burst or a stalled beat keeps the bus; otherwise alternate.
    always_comb begin
        g_rd = 1'b0;
        g_wr = 1'b0;
        if (s_q.wr_active || s_q.lock == LK_WR) begin
            g_wr = 1'b1;
        end else if (s_q.lock == LK_RD) begin
            g_rd = 1'b1;
        end else if (wr_pend && (!rd_pend || !s_q.last_wr)) begin
            g_wr = 1'b1;
        end else if (rd_pend) begin
            g_rd = 1'b1;
        end
    end

    assign ob_valid = g_rd | g_wr;
    assign ob_wr    = g_wr;
    assign ob_addr  = g_wr ? (DST_BASE | (AW'(s_q.wr_sent) << OFS))
                           : (AW'(s_q.rd_issued) << OFS);
    assign ob_tag   = s_q.rd_issued[TW-1:0];
    assign ob_data  = g_wr ? ws_data : '0;
    assign ob_last  = g_rd | (g_wr & ws_last);
    assign ob_fire  = ob_valid & ob_ready;
    assign ws_go    = ob_fire & g_wr;
    assign rob_clr  = start & !s_q.busy;

    assign busy = s_q.busy;
    assign done = s_q.done;
    assign err  = s_q.err;

    always_comb begin
        s_d = s_q;
        if (ob_valid && !ob_ready) s_d.lock = g_wr ? LK_WR : LK_RD;
        else                       s_d.lock = LK_IDLE;

        if (ob_fire && g_rd) begin
            s_d.rd_issued = s_q.rd_issued + 1'b1;
            s_d.last_wr   = 1'b0;
        end
        if (rob_freed) begin
            s_d.rd_drained = s_q.rd_drained + 1'b1;
        end
        if (ws_go) begin
            s_d.wr_active = !ws_last;
            if (ws_last) begin
                s_d.wr_sent = s_q.wr_sent + 1'b1;
                s_d.last_wr = 1'b1;
                if ((s_q.wr_sent + 1'b1) == s_q.len) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
            end
        end

        if (start && !s_q.busy) begin
            s_d.done       = 1'b0;
            s_d.last_wr    = 1'b0;
            s_d.wr_active  = 1'b0;
            s_d.rd_issued  = '0;
            s_d.rd_drained = '0;
            s_d.wr_sent    = '0;
            if (job_len > LENW'(MAX_BURSTS)) begin
                s_d.err  = 1'b1;
                s_d.len  = '0;
            end else begin
                s_d.err  = 1'b0;
                s_d.len  = CNTW'(job_len);
                s_d.busy = (job_len != '0);
                s_d.done = (job_len == '0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pull_dma_chk.sv
`timescale 1ns/1ps
module pull_dma_chk #(
    parameter int DW   = 64,
    parameter int AW   = 21,
    parameter int TAGS = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    busy,
    input logic                    done,
    input logic                    err,
    input logic                    ob_valid,
    input logic                    ob_ready,
    input logic                    ob_wr,
    input logic [AW-1:0]           ob_addr,
    input logic [$clog2(TAGS)-1:0] ob_tag,
    input logic [DW-1:0]           ob_data,
    input logic                    ob_last,
    input logic                    src_valid,
    input logic                    src_ready,
    input logic [DW-1:0]           src_data,
    input logic                    src_last
);
    logic [31:0] outst_q, src_bursts_q, wr_started_q;
    logic        in_wr_q;
    logic        rd_fire, wr_fire, src_end;

    assign rd_fire = ob_valid && ob_ready && !ob_wr;
    assign wr_fire = ob_valid && ob_ready && ob_wr;
    assign src_end = src_valid && src_ready && src_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q      <= '0;
            src_bursts_q <= '0;
            wr_started_q <= '0;
            in_wr_q      <= 1'b0;
        end else begin
            outst_q <= outst_q + (rd_fire ? 32'd1 : 32'd0) - (src_end ? 32'd1 : 32'd0);
            if (src_end) src_bursts_q <= src_bursts_q + 1'b1;
            if (wr_fire && !in_wr_q) wr_started_q <= wr_started_q + 1'b1;
            if (wr_fire) in_wr_q <= !ob_last;
        end
    end

    // R4
    outst_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q <= 32'(TAGS));

    // R10
    ob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_valid && !ob_ready) |=> (ob_valid && $stable(ob_wr) && $stable(ob_addr)
                                     && $stable(ob_tag) && $stable(ob_data)));

    // R6
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && !src_ready) |=> (src_valid && $stable(src_data)));

    // R7
    wr_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !ob_last) |=> (ob_valid && ob_wr));

    // R8
    wr_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !in_wr_q) |-> (wr_started_q < src_bursts_q));

    // R3
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_valid && !ob_wr) |-> ob_last);

    // R2
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind pull_dma pull_dma_chk #(.DW(DW), .AW(AW), .TAGS(TAGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .ob_valid  (ob_valid),
    .ob_ready  (ob_ready),
    .ob_wr     (ob_wr),
    .ob_addr   (ob_addr),
    .ob_tag    (ob_tag),
    .ob_data   (ob_data),
    .ob_last   (ob_last),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .src_data  (src_data),
    .src_last  (src_last)
);

// File: tb/pull_dma_test.sv
`timescale 1ns/1ps
module pull_dma_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB = 16384;
    localparam int NJOB = 7;
    // {length[31:16], outbound ready % [15:8], core ready % [7:0]}
    localparam logic [31:0] JOBS [NJOB] = '{
        {16'd1,     8'd100, 8'd100},
        {16'd3,     8'd60,  8'd80},
        {16'd20,    8'd100, 8'd100},
        {16'd0,     8'd100, 8'd100},
        {16'd16385, 8'd100, 8'd100},
        {16'd40,    8'd30,  8'd40},
        {16'd65535, 8'd50,  8'd50}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] job_len = '0;
    logic        busy, done, err;
    logic        ob_valid, ob_wr, ob_last;
    logic        ob_ready = 1'b0;
    logic [20:0] ob_addr;
    logic [2:0]  ob_tag;
    logic [63:0] ob_data;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_tag = '0;
    logic [63:0] cpl_data = '0;
    logic        src_valid, src_last;
    logic        src_ready = 1'b0;
    logic [63:0] src_data;
    logic        res_valid = 1'b0;
    logic        res_ready;
    logic [63:0] res_data = '0;

    pull_dma uut (
        .clk(clk), .rst_n(rst_n), .start(start), .job_len(job_len),
        .busy(busy), .done(done), .err(err),
        .ob_valid(ob_valid), .ob_ready(ob_ready), .ob_wr(ob_wr), .ob_addr(ob_addr),
        .ob_tag(ob_tag), .ob_data(ob_data), .ob_last(ob_last),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_data(cpl_data),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data), .src_last(src_last),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int ob_pct = 100, src_pct = 100;
    int cur_len = 0;
    int rd_n = 0, src_n = 0, wr_bursts = 0, wr_beat = 0, res_acc = 0;
    bit last_was_wr = 0, in_wr = 0, done_due = 0, mon_en = 0;
    bit prev_ob_stall = 0, prev_src_stall = 0, prev_wr = 0;
    logic [20:0] prev_addr = '0;
    logic [63:0] prev_src = '0;
    bit pend_v [8];
    int pend_base [8];
    int pend_b [8];
    logic [63:0] core_q [1024];

    function automatic logic [63:0] srcword(input int i);
        return {32'hC0DE0000 + i, i * 32'h9E3779B1};
    endfunction

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Stimulus drivers: change one time unit after the rising edge.
    always @(posedge clk) begin
        #1;
        ob_ready  = (($urandom % 100) < ob_pct);
        src_ready = (($urandom % 100) < src_pct);
        res_valid = (res_acc < src_n) && (($urandom % 100) < 70);
        res_data  = core_q[res_acc % 1024];
        cpl_valid = 1'b0;
        if (($urandom % 4) != 0) begin
            automatic int st = $urandom % 8;
            for (int i = 0; i < 8; i++) begin
                automatic int t = (st + i) % 8;
                if (!cpl_valid && pend_v[t]) begin
                    cpl_valid = 1'b1;
                    cpl_tag   = 3'(t);
                    cpl_data  = srcword(pend_base[t] / 8 + pend_b[t]);
                end
            end
        end
    end

    // Monitor: samples on the falling edge, ahead of the edge that completes a handshake.
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            automatic int fill = res_acc - 8 * wr_bursts;
            automatic int drained = src_n / 8;
            // R12
            chk(res_ready == (fill < 8), "R12 res_ready vs staged count", res_ready, (fill < 8));
            if (done_due) begin
                chk(done && !busy, "R11 done one cycle after final write beat", {busy, done}, 2'b01);
                done_due = 0;
            end
            if (prev_ob_stall)
                chk(ob_valid && ob_wr == prev_wr && ob_addr == prev_addr,
                    "R10 outbound held while stalled", ob_addr, prev_addr);
            if (prev_src_stall)
                chk(src_valid && src_data == prev_src, "R6 source word held while stalled", src_data, prev_src);
            if (ob_valid && !ob_wr && ob_ready) begin
                chk(ob_addr == 21'(rd_n * 64), "R3 read address", ob_addr, 21'(rd_n * 64));
                chk(ob_tag == 3'(rd_n % 8) && ob_last, "R3 read tag/last", {ob_last, ob_tag}, {1'b1, 3'(rd_n % 8)});
                chk(!pend_v[ob_tag] && (rd_n - drained) < 8, "R4 tag free and outstanding below 8",
                    rd_n - drained, 7);
                pend_v[ob_tag] = 1;
                pend_base[ob_tag] = int'(ob_addr);
                pend_b[ob_tag] = 0;
                rd_n++;
                last_was_wr = 0;
            end
            if (ob_valid && ob_wr) begin
                if (!prev_ob_stall && !in_wr) begin
                    automatic bit rd_pend = busy && rd_n < cur_len && (rd_n - drained) < 8;
                    chk(!(last_was_wr && rd_pend), "R9 grant alternates to waiting read", 1, 0);
                    chk(wr_bursts < drained, "R8 write burst after its source burst", wr_bursts, drained);
                end
                if (ob_ready) begin
                    automatic int idx = wr_bursts * 8 + wr_beat;
                    chk(ob_addr == 21'h100000 + 21'(wr_bursts * 64), "R7 write address",
                        ob_addr, 21'h100000 + 21'(wr_bursts * 64));
                    chk(ob_data == ~srcword(idx), "R7 write data", ob_data, ~srcword(idx));
                    chk(ob_last == (wr_beat == 7), "R7 write last", ob_last, (wr_beat == 7));
                    if (wr_beat == 7) begin
                        wr_beat = 0;
                        in_wr = 0;
                        wr_bursts++;
                        last_was_wr = 1;
                        if (wr_bursts == cur_len) done_due = 1;
                    end else begin
                        wr_beat++;
                        in_wr = 1;
                    end
                end
            end
            if (src_valid && src_ready) begin
                chk(src_data == srcword(src_n), "R5 source order", src_data, srcword(src_n));
                chk(src_last == (src_n % 8 == 7), "R5 burst end marker", src_last, (src_n % 8 == 7));
                core_q[src_n % 1024] = ~src_data;
                src_n++;
            end
            if (res_valid && res_ready) res_acc++;
            if (cpl_valid) begin
                pend_b[cpl_tag]++;
                if (pend_b[cpl_tag] == 8) pend_v[cpl_tag] = 0;
            end
            prev_ob_stall  = ob_valid && !ob_ready;
            prev_wr        = ob_wr;
            prev_addr      = ob_addr;
            prev_src_stall = src_valid && !src_ready;
            prev_src       = src_data;
        end
    end

    task automatic run_job(input int len, input int obp, input int srcp, input bit poke);
        ob_pct = obp; src_pct = srcp; cur_len = len;
        rd_n = 0; src_n = 0; wr_bursts = 0; wr_beat = 0; res_acc = 0;
        last_was_wr = 0; in_wr = 0;
        @(posedge clk); #1; start = 1'b1; job_len = 16'(len);
        @(posedge clk); #1; start = 1'b0;
        @(negedge clk);
        if (len > MAXB) begin
            automatic int seen = 0;
            chk(err && !busy && !done, "R2 oversize start rejected", {err, busy, done}, 3'b100);
            repeat (16) begin
                @(negedge clk);
                if (ob_valid) seen++;
            end
            chk(seen == 0 && rd_n == 0, "R2 no request after rejection", seen, 0);
        end else if (len == 0) begin
            chk(done && !busy && !err, "R11 zero-length job", {err, busy, done}, 3'b001);
        end else begin
            chk(busy && !err && !done, "R2 accepted start clears flags", {err, busy, done}, 3'b010);
            if (poke) begin
                repeat (30) @(negedge clk);
                @(posedge clk); #1; start = 1'b1; job_len = 16'd2;
                @(posedge clk); #1; start = 1'b0;
            end
            while (!done) @(negedge clk);
            chk(rd_n == len, "R3 read request count", rd_n, len);
            chk(src_n == len * 8, "R5 source beat count", src_n, len * 8);
            chk(wr_bursts == len, poke ? "R2 start while busy ignored" : "R7 write burst count",
                wr_bursts, len);
            chk(!err, "R2 err clear after accepted job", err, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            pend_v[i] = 0; pend_b[i] = 0; pend_base[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!busy && !done && !err && !ob_valid && !src_valid, "R1 reset state",
            {busy, done, err, ob_valid, src_valid}, 5'b0);
        mon_en = 1;
        for (int j = 0; j < NJOB; j++) begin
            run_job(int'(JOBS[j][31:16]), int'(JOBS[j][15:8]), int'(JOBS[j][7:0]), 1'b0);
        end
        // Directed corner cases
        run_job(12, 50, 50, 1'b1);
        run_job(MAXB + 1, 100, 100, 1'b0);
        run_job(9, 100, 20, 1'b0);
        run_job(0, 100, 100, 1'b0);
        run_job(16, 20, 100, 1'b0);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule